// File: doc/BRIEF.md
# Serial Save-Memory Device Model

This block behaves as a small nonvolatile save chip of the EEPROM or flash kind behind a byte-wide serial port. The host exchanges one byte at a time: it presents a transmitted byte with a one-cycle strobe, and the block returns exactly one response byte on the following cycle. While chip select stays asserted, the block carries its command state from byte to byte. The first byte of a selection is the command. Read and write commands then collect a big-endian address, followed by a stream of data bytes.

The address is two bytes long when the EEPROM type is selected and three bytes long for the flash type. The type is sampled when a command byte arrives. Data lives in an internal byte array whose size is a power of two, and addresses wrap modulo that size. A status register exposes a write-enable latch in bit 1. Writes are stored only while that latch is set.

Chip select is driven by configuration writes. A configuration write that selects serial mode while hold was off counts as a release: it returns the command state to waiting-for-command. Hold then takes the new configured value, so a transaction is opened with hold on and closed by writing hold off.

States are named in the requirements:
- `ST_IDLE` waits for a command.
- `ST_ADDR` collects the address.
- `ST_READ` and `ST_WRITE` stream data.
- `ST_STATUS` returns the status register.
- `ST_NOP` absorbs bytes without effect.

Transitions:
- `ST_IDLE` moves to `ST_ADDR` on a read or write command, to `ST_STATUS` on a status read, and to `ST_NOP` on any other command.
- `ST_ADDR` moves to `ST_READ` or `ST_WRITE` after its last address byte.
- Any state returns to `ST_IDLE` on a release.

Top module: `spi_save_mem`

## Requirements
- R1: After reset `rsp_valid` is 0, `rsp_byte` is 0xFF, the status register reads 0x00 and hold is off.
- R2: Every exchange strobe (`xfer_valid` high while `cfg_wr` is low) produces `rsp_valid` high for exactly one cycle, on the next cycle. No other cycle has `rsp_valid` high.
- R3: In `ST_IDLE` the exchanged byte is latched as the command and the address accumulator clears. The response is 0xFF.
- R4: Commands 0x03 and 0x02 go to `ST_ADDR`. `ST_ADDR` takes 2 address bytes when `dev_flash` is 0 and 3 when it is 1, most significant byte first. Each address byte answers 0xFF.
- R5: Command byte 0x06 sets status bit 1 (write enable) and command byte 0x04 clears it. Both lead to `ST_NOP`, where bytes answer 0xFF.
- R6: Command 0x05 goes to `ST_STATUS`. Every following byte returns the status register: bit 1 is write enable, and all other bits are 0.
- R7: In `ST_READ` each byte returns the array byte at the current address, and the address then increments.
- R8: In `ST_WRITE` each byte answers 0xFF and the address increments. The byte is stored only when write enable is set; otherwise the array is unchanged.
- R9: A configuration write with `cfg_spi_mode`=1 while hold is off returns the block to `ST_IDLE`. With `cfg_spi_mode`=1, hold becomes `cfg_hold`. With `cfg_spi_mode`=0, the write changes nothing.
- R10: A release that ends a transaction which stored at least one byte clears write enable.
- R11: Addresses wrap modulo `MEM_BYTES`. Address bits above the array size are ignored.
- R12: Any command byte other than 0x02, 0x03, 0x04, 0x05 and 0x06 leads to `ST_NOP`. There, bytes answer 0xFF and change neither the status register nor the array.
- R13: Storage never written since reset reads as 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_spi_mode | input | 1 | Configuration selects serial mode |
| cfg_hold | input | 1 | Configuration chip-select hold value |
| dev_flash | input | 1 | 1 selects flash type (3-byte address), 0 selects EEPROM type (2-byte address) |
| xfer_valid | input | 1 | Byte exchange strobe |
| xfer_tx | input | 8 | Byte sent by the host |
| rsp_valid | output | 1 | Response byte valid |
| rsp_byte | output | 8 | Byte returned to the host |

## Verification
A state held wrongly shows up on the very next response byte.

A command latched in the wrong phase turns a data byte into 0xFF, or turns 0xFF into data. A miscounted address phase shifts every read by one position. A write-enable latch that stays set or clears early appears only later: it surfaces in a status read or in the readback of a write that should or should not have landed. The bench therefore follows each write with a status read and a readback, so that the fault shows within a few exchanges.

// File: rtl/spi_save_pkg.sv
package spi_save_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_READ,
        ST_WRITE,
        ST_STATUS,
        ST_NOP
    } save_state_t;

    localparam logic [7:0] OP_WRITE  = 8'h02;
    localparam logic [7:0] OP_READ   = 8'h03;
    localparam logic [7:0] OP_WRDIS  = 8'h04;
    localparam logic [7:0] OP_STATUS = 8'h05;
    localparam logic [7:0] OP_WREN   = 8'h06;
    localparam logic [7:0] IDLE_BYTE = 8'hFF;

    function automatic save_state_t route_command(input logic [7:0] op);
        save_state_t nxt;
        unique case (op)
            OP_READ, OP_WRITE: nxt = ST_ADDR;
            OP_STATUS:         nxt = ST_STATUS;
            default:           nxt = ST_NOP;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/spi_save_array.sv
module spi_save_array #(
    parameter int DEPTH = 256,
    parameter int IW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [7:0]    wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [7:0]    rd_data
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells[i] <= 8'hFF;
            end
        end else if (wr_en) begin
            cells[wr_idx] <= wr_data;
        end
    end

    assign rd_data = cells[rd_idx];
endmodule

// File: rtl/spi_save_mem.sv
module spi_save_mem
    import spi_save_pkg::*;
#(
    parameter int MEM_BYTES = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic       cfg_spi_mode,
    input  logic       cfg_hold,
    input  logic       dev_flash,
    input  logic       xfer_valid,
    input  logic [7:0] xfer_tx,
    output logic       rsp_valid,
    output logic [7:0] rsp_byte
);
    localparam int AW = $clog2(MEM_BYTES);

    save_state_t   state_q, state_d;
    logic [7:0]    cmd_q;
    logic [AW-1:0] addr_q;
    logic [1:0]    left_q;
    logic          wel_q, hold_q, wrote_q;
    logic          release_evt, xfer_go, store_en;
    logic [7:0]    rd_data;

    assign release_evt = cfg_wr && cfg_spi_mode && !hold_q;
    assign xfer_go     = xfer_valid && !cfg_wr;
    assign store_en    = xfer_go && (state_q == ST_WRITE) && wel_q;

    spi_save_array #(.DEPTH(MEM_BYTES)) i_array (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_en),
        .wr_idx  (addr_q),
        .wr_data (xfer_tx),
        .rd_idx  (addr_q),
        .rd_data (rd_data)
    );

    // Next state
    always_comb begin
        state_d = state_q;
        if (release_evt) begin
            state_d = ST_IDLE;
        end else if (xfer_go) begin
            unique case (state_q)
                ST_IDLE:   state_d = route_command(xfer_tx);
                ST_ADDR:   if (left_q == 2'd1)
                               state_d = (cmd_q == OP_READ) ? ST_READ : ST_WRITE;
                ST_READ, ST_WRITE, ST_STATUS, ST_NOP: state_d = state_q;
                default:   state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Command, address and status bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q   <= 8'h00;
            addr_q  <= '0;
            left_q  <= 2'd0;
            wel_q   <= 1'b0;
            hold_q  <= 1'b0;
            wrote_q <= 1'b0;
        end else if (cfg_wr) begin
            if (cfg_spi_mode) begin
                hold_q <= cfg_hold;
                if (!hold_q) begin
                    wrote_q <= 1'b0;
                    if (wrote_q) wel_q <= 1'b0;
                end
            end
        end else if (xfer_valid) begin
            unique case (state_q)
                ST_IDLE: begin
                    cmd_q  <= xfer_tx;
                    addr_q <= '0;
                    left_q <= dev_flash ? 2'd3 : 2'd2;
                    if (xfer_tx == OP_WREN)  wel_q <= 1'b1;
                    if (xfer_tx == OP_WRDIS) wel_q <= 1'b0;
                end
                ST_ADDR: begin
                    addr_q <= AW'({addr_q, xfer_tx});
                    left_q <= left_q - 2'd1;
                end
                ST_READ: addr_q <= addr_q + 1'b1;
                ST_WRITE: begin
                    addr_q <= addr_q + 1'b1;
                    if (wel_q) wrote_q <= 1'b1;
                end
                ST_STATUS, ST_NOP: ;
                default: ;
            endcase
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_byte  <= IDLE_BYTE;
        end else begin
            rsp_valid <= xfer_go;
            if (xfer_go) begin
                unique case (state_q)
                    ST_READ:   rsp_byte <= rd_data;
                    ST_STATUS: rsp_byte <= {6'b0, wel_q, 1'b0};
                    default:   rsp_byte <= IDLE_BYTE;
                endcase
            end
        end
    end
endmodule

// File: rtl/spi_save_chk.sv
module spi_save_chk
    import spi_save_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_wr,
    input logic        cfg_spi_mode,
    input logic        cfg_hold,
    input logic        xfer_valid,
    input logic        rsp_valid,
    input logic [7:0]  rsp_byte,
    input save_state_t state_q,
    input logic        hold_q
);
    a_r2_reply_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !cfg_wr) |=> rsp_valid);

    a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !(xfer_valid && !cfg_wr) |=> !rsp_valid);

    a_r3_command_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !cfg_wr && state_q == ST_IDLE) |=> rsp_byte == 8'hFF);

    a_r4_address_ff: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !cfg_wr && state_q == ST_ADDR) |=> rsp_byte == 8'hFF);

    a_r6_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_valid && !cfg_wr && state_q == ST_STATUS) |=>
            (rsp_byte[7:2] == 6'd0 && rsp_byte[0] == 1'b0));

    a_r9_release_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_spi_mode && !hold_q) |=> state_q == ST_IDLE);

    a_r9_hold_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_spi_mode) |=> hold_q == $past(cfg_hold));
endmodule

bind spi_save_mem spi_save_chk i_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_wr       (cfg_wr),
    .cfg_spi_mode (cfg_spi_mode),
    .cfg_hold     (cfg_hold),
    .xfer_valid   (xfer_valid),
    .rsp_valid    (rsp_valid),
    .rsp_byte     (rsp_byte),
    .state_q      (state_q),
    .hold_q       (hold_q)
);

// File: tb/test_spi_save_mem.sv
module test_spi_save_mem;
    localparam int CLK_PERIOD = 10;
    localparam int MEM = 256;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0, cfg_spi_mode = 1'b0, cfg_hold = 1'b0, dev_flash = 1'b0;
    logic       xfer_valid = 1'b0;
    logic [7:0] xfer_tx = 8'h00;
    logic       rsp_valid;
    logic [7:0] rsp_byte;

    int total = 0, failed = 0;
    bit done = 0;

    // reference model state
    int m_state = 0, m_cmd = 0, m_addr = 0, m_left = 0;
    bit m_wel = 0, m_hold = 0, m_wrote = 0;
    int m_mem [MEM];

    spi_save_mem #(.MEM_BYTES(MEM)) i_spi_save_mem (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_spi_mode(cfg_spi_mode),
        .cfg_hold(cfg_hold), .dev_flash(dev_flash), .xfer_valid(xfer_valid),
        .xfer_tx(xfer_tx), .rsp_valid(rsp_valid), .rsp_byte(rsp_byte)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            failed++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input bit mode, input bit hold, input string tag);
        if (mode) begin
            if (!m_hold) begin
                m_state = 0;
                if (m_wrote) m_wel = 0;
                m_wrote = 0;
            end
            m_hold = hold;
        end
        @(negedge clk);
        cfg_wr = 1; cfg_spi_mode = mode; cfg_hold = hold;
        @(negedge clk);
        cfg_wr = 0; cfg_spi_mode = 0; cfg_hold = 0;
        check({tag, " no reply to cfg"}, rsp_valid, 0);
    endtask

    task automatic xfer(input int tx, input string tag);
        int exp;
        exp = 255;
        case (m_state)
            0: begin
                m_cmd = tx; m_addr = 0; m_left = dev_flash ? 3 : 2;
                if (tx == 6) m_wel = 1;
                if (tx == 4) m_wel = 0;
                m_state = (tx == 3 || tx == 2) ? 1 : (tx == 5) ? 4 : 5;
            end
            1: begin
                m_addr = (m_addr * 256 + tx) % MEM;
                m_left--;
                if (m_left == 0) m_state = (m_cmd == 3) ? 2 : 3;
            end
            2: begin exp = m_mem[m_addr]; m_addr = (m_addr + 1) % MEM; end
            3: begin
                if (m_wel) begin m_mem[m_addr] = tx; m_wrote = 1; end
                m_addr = (m_addr + 1) % MEM;
            end
            4: exp = m_wel ? 2 : 0;
            default: ;
        endcase
        @(negedge clk);
        xfer_valid = 1; xfer_tx = tx[7:0];
        @(negedge clk);
        xfer_valid = 0;
        check({tag, " R2 valid"}, rsp_valid, 1);
        check(tag, rsp_byte, exp);
        @(negedge clk);
        check({tag, " R2 single"}, rsp_valid, 0);
    endtask

    task automatic open_t;  cfg(1, 1, "R9 open");  endtask
    task automatic close_t; cfg(1, 0, "R9 close"); endtask

    task automatic status_is(input int exp, input string tag);
        open_t(); xfer(5, tag); xfer(0, tag);
        check({tag, " model"}, m_wel ? 2 : 0, exp);
        close_t();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failed++; total++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", total - failed, total);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < MEM; i++) m_mem[i] = 255;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R1 reset valid", rsp_valid, 0);
        check("R1 reset byte", rsp_byte, 8'hFF);
        status_is(0, "R1 R6 status after reset");

        // R13 / R7: unwritten storage, EEPROM addressing
        open_t(); xfer(3, "R3 cmd"); xfer(0, "R4 a1"); xfer(8'h10, "R4 a0");
        xfer(0, "R13 R7 read"); xfer(0, "R13 R7 read"); close_t();

        // R8: write without enable ignored
        open_t(); xfer(2, "R3 cmd"); xfer(0, "R4"); xfer(8'h10, "R4");
        xfer(8'hAA, "R8 no wel"); xfer(8'hBB, "R8 no wel"); close_t();
        open_t(); xfer(3, "R3"); xfer(0, "R4"); xfer(8'h10, "R4");
        xfer(0, "R8 readback unchanged"); close_t();

        // R5 set, R8 write, R10 clear
        open_t(); xfer(6, "R5 wren"); xfer(0, "R5 nop"); close_t();
        status_is(2, "R5 R6 wel set");
        open_t(); xfer(2, "R3"); xfer(0, "R4"); xfer(8'h10, "R4");
        xfer(8'hAA, "R8 store"); xfer(8'hBB, "R8 store"); close_t();
        open_t(); close_t();
        status_is(0, "R10 wel cleared");
        open_t(); xfer(3, "R3"); xfer(0, "R4"); xfer(8'h10, "R4");
        xfer(0, "R7 data0"); xfer(0, "R7 data1"); xfer(0, "R7 R13 next"); close_t();

        // R4 flash width, R11 wrap
        dev_flash = 1;
        open_t(); xfer(6, "R5"); close_t();
        open_t(); xfer(2, "R3"); xfer(8'h12, "R4 f2"); xfer(0, "R4 f1"); xfer(8'hFF, "R4 f0");
        xfer(8'h11, "R11 end"); xfer(8'h22, "R11 wrap"); close_t();
        open_t(); xfer(3, "R3"); xfer(8'hAB, "R4"); xfer(0, "R4"); xfer(8'hFF, "R4");
        xfer(0, "R11 R7 end"); xfer(0, "R11 R7 wrapped"); close_t();
        dev_flash = 0;
        open_t(); xfer(3, "R3"); xfer(8'h7F, "R4"); xfer(8'hFF, "R4");
        xfer(0, "R11 R4 eeprom high bits"); close_t();

        // R5 clear
        open_t(); xfer(6, "R5"); close_t();
        status_is(2, "R5 set again");
        open_t(); xfer(4, "R5 wrdi"); close_t();
        status_is(0, "R5 cleared");

        // R12 unknown command
        open_t(); xfer(6, "R5"); close_t();
        open_t(); xfer(8'h9A, "R12 cmd"); xfer(8'h00, "R12 data"); xfer(8'h10, "R12 data");
        xfer(8'h55, "R12 data"); close_t();
        status_is(2, "R12 status kept");
        open_t(); xfer(3, "R3"); xfer(0, "R4"); xfer(8'h10, "R4");
        xfer(0, "R12 array kept"); close_t();

        // R9 hold semantics
        open_t(); xfer(5, "R9 cmd");
        cfg(1, 1, "R9 reopen held");
        xfer(0, "R9 still status");
        cfg(0, 0, "R9 non-spi cfg");
        xfer(0, "R9 non-spi ignored");
        cfg(1, 0, "R9 drop hold");
        xfer(0, "R9 no reset while held");
        cfg(1, 1, "R9 release");
        xfer(3, "R9 R3 new command");
        xfer(0, "R4"); xfer(8'h10, "R4"); xfer(0, "R9 R7 read after release");
        close_t();

        done = 1;
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule